// File: doc/BRIEF.md
# General-Purpose Up-Counting Timer

The block is a free-running 32-bit up-counter clocked by its functional clock and set up through a small memory-mapped register file with a single-cycle write port and a combinational read port. Software starts and stops the count, picks between a one-shot run and an auto-reloading run, and can slow the count with a power-of-two prescaler. A compare unit flags the cycle on which the count reaches a programmed value. A capture unit latches the count when a selected edge appears on an external input.

Three sticky status flags (compare hit, overflow, capture) are cleared by writing ones. They are masked by an enable register and ORed onto a single interrupt line. A soft-reset request returns every register to its reset value. A reset-done flag rises again once the internal reset sequence has run its fixed number of cycles.

Top module: `gpt_timer_core`

## Requirements
- R1: After power-on reset every register reads 0 and `irq` is 0. The reset-done flag (bit 0 at offset 0x14) reads 0 for RST_CYCLES clock edges after reset release and reads 1 from then on.
- R2: Control bit 0 (offset 0x24) runs the counter when 1. When it is 0, the counter at offset 0x28 holds its value.
- R3: With the prescaler off (control bit 5 = 0), a running counter advances by one on every clock edge, starting with the first edge after the edge that wrote the run bit.
- R4: With control bit 5 = 1 and prescale value v in control bits 4:2, the counter advances once every 2^(v+1) clock edges. The first advance comes on the 2^(v+1)-th edge after the run bit was written.
- R5: With auto-reload set (control bit 1), an advance past all-ones loads the counter from the load register (offset 0x2C), leaves the run bit set and sets status bit 1 (offset 0x18).
- R6: With auto-reload clear, an advance past all-ones leaves the counter at 0, clears the run bit and sets status bit 1. The counter then stays at 0.
- R7: With compare enabled (control bit 6), status bit 0 is set on the edge at which the counter advances to the value of the match register (offset 0x38). With compare disabled, that bit is not set.
- R8: Control bits 9:8 select the capture edge: 0 none, 1 rising, 2 falling, 3 both. The capture input passes through a 2-stage synchronizer. On the third clock edge after a qualifying input change, the count held before that edge is stored in the capture register (offset 0x3C) and status bit 2 is set.
- R9: A write of any data to the trigger register (offset 0x30) copies the load register into the counter.
- R10: The counter, load and match registers are directly writable and read back the value written.
- R11: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. A bit stays set until it is cleared.
- R12: `irq` is 1 exactly when some status bit is set whose enable bit (offset 0x1C, same bit positions) is also 1.
- R13: Writing 1 to bit 1 at offset 0x40 resets all timer registers at that edge. The reset-done flag then reads 0 for RST_CYCLES edges, and register writes made during that window are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 8 | Byte offset of the register written |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Byte offset of the register read |
| rd_data | output | 32 | Read data, combinational from `rd_addr` |
| cap_in | input | 1 | Asynchronous capture input |
| irq | output | 1 | Masked OR of the status flags |

## Verification
The hardest conditions to reach are the edges of long counting windows. The largest prescale setting needs hundreds of cycles per step, and overflow needs 2^32 steps from reset. The bench reaches the overflow in a few edges by writing the counter directly to one or two below all-ones. It sweeps every prescale value and checks the count just before and just after each step boundary. Capture timing through the synchronizer is pinned down by changing the input while the counter runs and predicting the latched count from the edge count. The bench also sweeps all four edge modes against both input directions with the counter stopped at a distinct value per case.

// File: rtl/gpt_pkg.sv
package gpt_pkg;

    // Register byte offsets
    localparam int OFF_SYS_STAT = 'h14;
    localparam int OFF_STATUS   = 'h18;
    localparam int OFF_IRQ_EN   = 'h1C;
    localparam int OFF_CTRL     = 'h24;
    localparam int OFF_COUNT    = 'h28;
    localparam int OFF_LOAD     = 'h2C;
    localparam int OFF_TRIGGER  = 'h30;
    localparam int OFF_MATCH    = 'h38;
    localparam int OFF_CAPTURE  = 'h3C;
    localparam int OFF_IF_CTRL  = 'h40;

    // Control word bit positions
    localparam int B_RUN      = 0;
    localparam int B_AUTO     = 1;
    localparam int B_PRE_LSB  = 2;
    localparam int B_PRE_EN   = 5;
    localparam int B_CMP_EN   = 6;
    localparam int B_CAP_LSB  = 8;

    // Status / enable bit positions
    localparam int S_MATCH    = 0;
    localparam int S_OVF      = 1;
    localparam int S_CAPT     = 2;
    localparam int NUM_FLAGS  = 3;

    // Interface control soft-reset bit
    localparam int B_SOFT_RST = 1;

    typedef enum logic [1:0] {
        CAP_OFF  = 2'd0,
        CAP_RISE = 2'd1,
        CAP_FALL = 2'd2,
        CAP_BOTH = 2'd3
    } cap_mode_e;

endpackage

// File: rtl/gpt_prescaler.sv
module gpt_prescaler #(
    parameter int PRE_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             enable,
    input  logic [PRE_W-1:0] sel,
    output logic             tick
);
    localparam int PC_W = 1 << PRE_W;

    logic [PC_W-1:0] pc_d, pc_q;
    logic [PC_W-1:0] limit;

    always_comb begin
        limit = {PC_W{1'b1}} >> (PC_W - 1 - int'(sel));
        if (!run) begin
            pc_d = '0;
        end else if (pc_q == limit) begin
            pc_d = '0;
        end else begin
            pc_d = pc_q + 1'b1;
        end
        tick = enable ? (pc_q == limit) : 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
    end
endmodule

// File: rtl/gpt_edge_capture.sv
module gpt_edge_capture
    import gpt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sig_in,
    input  cap_mode_e mode,
    output logic      hit
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
    } edge_state_t;

    edge_state_t es_d, es_q;
    logic        now_lvl;
    logic        rise;
    logic        fall;

    always_comb begin
        es_d      = es_q;
        es_d.sync = {es_q.sync[SYNC_STAGES-2:0], sig_in};
        es_d.prev = es_q.sync[SYNC_STAGES-1];
        now_lvl   = es_q.sync[SYNC_STAGES-1];
        rise      = now_lvl & ~es_q.prev;
        fall      = ~now_lvl & es_q.prev;
        unique case (mode)
            CAP_RISE: hit = rise;
            CAP_FALL: hit = fall;
            CAP_BOTH: hit = rise | fall;
            default:  hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) es_q <= '0;
        else        es_q <= es_d;
    end
endmodule

// File: rtl/gpt_reset_seq.sv
module gpt_reset_seq #(
    parameter int RST_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_req,
    output logic busy
);
    localparam int RC_W = $clog2(RST_CYCLES + 1);

    logic [RC_W-1:0] rc_d, rc_q;

    always_comb begin
        if (soft_req) begin
            rc_d = RC_W'(RST_CYCLES);
        end else if (rc_q != '0) begin
            rc_d = rc_q - 1'b1;
        end else begin
            rc_d = rc_q;
        end
        busy = (rc_q != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rc_q <= RC_W'(RST_CYCLES);
        else        rc_q <= rc_d;
    end
endmodule

// File: rtl/gpt_timer_core.sv
module gpt_timer_core
    import gpt_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int ADDR_W      = 8,
    parameter int PRE_W       = 3,
    parameter int SYNC_STAGES = 2,
    parameter int RST_CYCLES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    input  logic              cap_in,
    output logic              irq
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic                 run;
        logic                 auto_rl;
        logic [PRE_W-1:0]     pre_val;
        logic                 pre_en;
        logic                 cmp_en;
        cap_mode_e            cap_mode;
        logic [CNT_W-1:0]     cnt;
        logic [CNT_W-1:0]     load;
        logic [CNT_W-1:0]     match;
        logic [CNT_W-1:0]     capt;
        logic [NUM_FLAGS-1:0] sts;
        logic [NUM_FLAGS-1:0] ien;
    } state_t;

    state_t st_d, st_q;

    logic                 tick;
    logic                 cap_hit;
    logic                 rst_busy;
    logic                 soft_req;
    logic                 wr_ok;
    logic [NUM_FLAGS-1:0] flag_set;
    logic [NUM_FLAGS-1:0] flag_clr;
    logic [CNT_W-1:0]     cnt_adv;

    gpt_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (st_q.run),
        .enable (st_q.pre_en),
        .sel    (st_q.pre_val),
        .tick   (tick)
    );

    gpt_edge_capture #(.SYNC_STAGES(SYNC_STAGES)) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_in (cap_in),
        .mode   (st_q.cap_mode),
        .hit    (cap_hit)
    );

    gpt_reset_seq #(.RST_CYCLES(RST_CYCLES)) u_rst (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_req (soft_req),
        .busy     (rst_busy)
    );

    // Next-state computation
    always_comb begin
        st_d     = st_q;
        flag_set = '0;
        flag_clr = '0;
        cnt_adv  = st_q.cnt + 1'b1;
        wr_ok    = wr_en && !rst_busy;
        soft_req = wr_ok && (wr_addr == ADDR_W'(OFF_IF_CTRL))
                   && wr_data[B_SOFT_RST];

        // Counting path
        if (st_q.run && tick) begin
            if (st_q.cnt == CNT_MAX) begin
                flag_set[S_OVF] = 1'b1;
                if (st_q.auto_rl) begin
                    st_d.cnt = st_q.load;
                end else begin
                    st_d.cnt = '0;
                    st_d.run = 1'b0;
                end
            end else begin
                st_d.cnt = cnt_adv;
            end
            if (st_q.cmp_en && (st_d.cnt == st_q.match)) begin
                flag_set[S_MATCH] = 1'b1;
            end
        end

        // Capture path
        if (cap_hit) begin
            st_d.capt        = st_q.cnt;
            flag_set[S_CAPT] = 1'b1;
        end

        // Register writes take priority over hardware updates
        if (wr_ok) begin
            unique case (wr_addr)
                ADDR_W'(OFF_CTRL): begin
                    st_d.run      = wr_data[B_RUN];
                    st_d.auto_rl  = wr_data[B_AUTO];
                    st_d.pre_val  = wr_data[B_PRE_LSB +: PRE_W];
                    st_d.pre_en   = wr_data[B_PRE_EN];
                    st_d.cmp_en   = wr_data[B_CMP_EN];
                    st_d.cap_mode = cap_mode_e'(wr_data[B_CAP_LSB +: 2]);
                end
                ADDR_W'(OFF_COUNT):   st_d.cnt   = wr_data;
                ADDR_W'(OFF_LOAD):    st_d.load  = wr_data;
                ADDR_W'(OFF_TRIGGER): st_d.cnt   = st_q.load;
                ADDR_W'(OFF_MATCH):   st_d.match = wr_data;
                ADDR_W'(OFF_STATUS):  flag_clr   = wr_data[NUM_FLAGS-1:0];
                ADDR_W'(OFF_IRQ_EN):  st_d.ien   = wr_data[NUM_FLAGS-1:0];
                default: ;
            endcase
        end

        // Hardware set wins over a same-cycle clear
        st_d.sts = (st_q.sts & ~flag_clr) | flag_set;

        if (soft_req || rst_busy) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Read mux
    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            ADDR_W'(OFF_SYS_STAT): rd_data[0] = !rst_busy;
            ADDR_W'(OFF_STATUS):   rd_data[NUM_FLAGS-1:0] = st_q.sts;
            ADDR_W'(OFF_IRQ_EN):   rd_data[NUM_FLAGS-1:0] = st_q.ien;
            ADDR_W'(OFF_CTRL): begin
                rd_data[B_RUN]              = st_q.run;
                rd_data[B_AUTO]             = st_q.auto_rl;
                rd_data[B_PRE_LSB +: PRE_W] = st_q.pre_val;
                rd_data[B_PRE_EN]           = st_q.pre_en;
                rd_data[B_CMP_EN]           = st_q.cmp_en;
                rd_data[B_CAP_LSB +: 2]     = st_q.cap_mode;
            end
            ADDR_W'(OFF_COUNT):    rd_data = st_q.cnt;
            ADDR_W'(OFF_LOAD):     rd_data = st_q.load;
            ADDR_W'(OFF_MATCH):    rd_data = st_q.match;
            ADDR_W'(OFF_CAPTURE):  rd_data = st_q.capt;
            ADDR_W'(OFF_IF_CTRL):  rd_data[B_SOFT_RST] = rst_busy;
            default: ;
        endcase
    end

    assign irq = |(st_q.sts & st_q.ien);

endmodule

// File: rtl/gpt_timer_checker.sv
module gpt_timer_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             irq,
    input logic             busy,
    input logic             run,
    input logic             auto_rl,
    input logic             tick,
    input logic [CNT_W-1:0] cnt,
    input logic [2:0]       sts
);
    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_en && !busy) |=> $stable(cnt)); // R2

    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !wr_en && !busy && cnt != {CNT_W{1'b1}})
        |=> (cnt == $past(cnt) + 1'b1)); // R3

    AST_ONESHOT_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !auto_rl && tick && !wr_en && cnt == {CNT_W{1'b1}})
        |=> (!run && cnt == '0)); // R6

    AST_AUTO_KEEPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (run && auto_rl && tick && !wr_en && !busy && cnt == {CNT_W{1'b1}})
        |=> (run && sts[1])); // R5

    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ((sts & $past(sts)) == $past(sts))); // R11

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (sts != 3'b000)); // R12

    AST_BUSY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!run && cnt == '0 && sts == 3'b000)); // R13
endmodule

bind gpt_timer_core gpt_timer_checker #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .irq     (irq),
    .busy    (rst_busy),
    .run     (st_q.run),
    .auto_rl (st_q.auto_rl),
    .tick    (tick),
    .cnt     (st_q.cnt),
    .sts     (st_q.sts)
);

// File: tb/tb_gpt_timer_core.sv
`timescale 1ns/1ps
module tb_gpt_timer_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        cap_in = 1'b0;
    logic        irq;

    int n_checks = 0;
    int n_errs   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    gpt_timer_core dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .cap_in(cap_in), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] got,
                         input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errs++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_errs++;
            n_checks++;
            $display("FAIL watchdog got=timeout exp=completion");
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        edges(3);
        rst_n = 1'b1;
        rd('h14, v); check("R1 reset-done low after release", v, 0);
        rd('h24, v); check("R1 ctrl reset", v, 0);
        rd('h28, v); check("R1 count reset", v, 0);
        rd('h18, v); check("R1 status reset", v, 0);
        check("R1 irq reset", {31'b0, irq}, 0);
        edges(3);
        rd('h14, v); check("R1 reset-done still low", v, 0);
        edges(1);
        rd('h14, v); check("R1 reset-done high", v, 1);

        // R10 direct writes and readback
        wr('h2C, 32'h1234_5678); rd('h2C, v); check("R10 load", v, 32'h1234_5678);
        wr('h38, 32'hCAFE_0001); rd('h38, v); check("R10 match", v, 32'hCAFE_0001);
        wr('h28, 32'h0000_0064); rd('h28, v); check("R10 count", v, 32'h64);
        edges(5);
        rd('h28, v); check("R2 stopped holds", v, 32'h64);

        // R3 unprescaled counting
        wr('h24, 32'h1);
        edges(7);
        rd('h28, v); check("R3 count every edge", v, 32'h64 + 7);
        wr('h24, 32'h0);
        rd('h28, v);
        begin
            logic [31:0] held;
            held = v;
            edges(4);
            rd('h28, v); check("R2 stop holds count", v, held);
        end

        // R4 prescaler sweep
        for (int pv = 0; pv < 8; pv++) begin
            int div;
            div = 2 << pv;
            wr('h24, 32'h0);
            wr('h28, 32'h0);
            wr('h24, 32'h1 | (32'h1 << 5) | (pv << 2));
            edges(div - 1);
            rd('h28, v); check($sformatf("R4 pv=%0d before first step", pv), v, 0);
            edges(1);
            rd('h28, v); check($sformatf("R4 pv=%0d first step", pv), v, 1);
            edges(2 * div);
            rd('h28, v); check($sformatf("R4 pv=%0d third step", pv), v, 3);
        end
        wr('h24, 32'h0);

        // R5 auto-reload overflow, R12 interrupt masking, R11 clear
        wr('h18, 32'h7);
        wr('h1C, 32'h0);
        wr('h2C, 32'h5);
        wr('h28, 32'hFFFF_FFFE);
        wr('h24, 32'h3);
        edges(1);
        rd('h28, v); check("R5 at all-ones", v, 32'hFFFF_FFFF);
        rd('h18, v); check("R5 no flag yet", v, 0);
        edges(1);
        rd('h28, v); check("R5 reloaded", v, 32'h5);
        rd('h18, v); check("R5 overflow flag", v, 32'h2);
        rd('h24, v); check("R5 still running", v, 32'h3);
        check("R12 irq masked", {31'b0, irq}, 0);
        wr('h1C, 32'h2);
        check("R12 irq enabled", {31'b0, irq}, 1);
        wr('h18, 32'h1);
        rd('h18, v); check("R11 write 0 leaves bit", v, 32'h2);
        wr('h18, 32'h2);
        rd('h18, v); check("R11 write 1 clears", v, 0);
        check("R12 irq drops", {31'b0, irq}, 0);
        wr('h24, 32'h0);

        // R6 one-shot overflow
        wr('h18, 32'h7);
        wr('h28, 32'hFFFF_FFFF);
        wr('h24, 32'h1);
        edges(1);
        rd('h28, v); check("R6 wrapped to 0", v, 0);
        rd('h24, v); check("R6 run cleared", v, 0);
        rd('h18, v); check("R6 overflow flag", v, 32'h2);
        edges(3);
        rd('h28, v); check("R6 stays stopped", v, 0);

        // R7 compare
        wr('h18, 32'h7);
        wr('h1C, 32'h1);
        wr('h38, 32'd10);
        wr('h28, 32'd5);
        wr('h24, 32'h1 | (32'h1 << 6));
        edges(4);
        rd('h18, v); check("R7 no hit before match", v, 0);
        edges(1);
        rd('h28, v); check("R7 count at match", v, 32'd10);
        rd('h18, v); check("R7 hit flag", v, 32'h1);
        check("R12 irq on match", {31'b0, irq}, 1);
        wr('h24, 32'h0);
        wr('h18, 32'h7);
        wr('h28, 32'd5);
        wr('h24, 32'h1);
        edges(6);
        rd('h18, v); check("R7 compare disabled", v, 0);
        wr('h24, 32'h0);
        wr('h1C, 32'h0);

        // R9 trigger
        wr('h2C, 32'd77);
        wr('h28, 32'd3);
        wr('h30, 32'hDEAD_BEEF);
        rd('h28, v); check("R9 trigger reload", v, 32'd77);
        rd('h2C, v); check("R9 load unchanged", v, 32'd77);

        // R8 capture mode sweep
        for (int m = 0; m < 4; m++) begin
            for (int dir = 0; dir < 2; dir++) begin
                bit exp_hit;
                logic [31:0] tag;
                tag = 32'(m * 16 + dir + 1);
                cap_in = (dir == 0) ? 1'b0 : 1'b1;
                edges(5);
                wr('h24, 32'(m) << 8);
                wr('h18, 32'h7);
                wr('h28, tag);
                cap_in = ~cap_in;
                edges(5);
                exp_hit = (m == 3) || (m == 1 && dir == 0) || (m == 2 && dir == 1);
                rd('h18, v);
                check($sformatf("R8 mode=%0d dir=%0d flag", m, dir), v, exp_hit ? 32'h4 : 0);
                if (exp_hit) begin
                    rd('h3C, v);
                    check($sformatf("R8 mode=%0d dir=%0d value", m, dir), v, tag);
                end
            end
        end
        // R8 capture timing on a running counter
        cap_in = 1'b0;
        wr('h24, 32'h0);
        edges(5);
        wr('h18, 32'h7);
        wr('h28, 32'd1000);
        wr('h24, 32'h1 | (32'h1 << 8));
        cap_in = 1'b1;
        edges(5);
        rd('h3C, v); check("R8 capture latency", v, 32'd1002);
        wr('h24, 32'h0);

        // R13 soft reset
        wr('h2C, 32'd9);
        wr('h1C, 32'h7);
        wr('h24, 32'h3);
        wr('h40, 32'h2);
        rd('h14, v); check("R13 reset-done low", v, 0);
        rd('h24, v); check("R13 ctrl cleared", v, 0);
        rd('h2C, v); check("R13 load cleared", v, 0);
        wr('h2C, 32'd123);
        rd('h2C, v); check("R13 write ignored while busy", v, 0);
        edges(1);
        rd('h14, v); check("R13 reset-done still low", v, 0);
        edges(1);
        rd('h14, v); check("R13 reset-done high", v, 1);
        wr('h2C, 32'd123);
        rd('h2C, v); check("R13 writes accepted after", v, 32'd123);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule